// File: doc/BRIEF.md
# Arithmetic Shift-Right Unit with Condition Flags

This block is the arithmetic right-shift execution slice of a small 16-bit coprocessor datapath. It takes a destination operand and shifts it right by a count of 0 to 16 places. The vacated upper bits are filled with copies of the operand's sign bit. The count comes from one of two sources, selected per operation: a 4-bit immediate field or a 16-bit source register value. Both sources have their own saturation rule. Alongside the shifted value the unit produces the four condition flags negative, zero, overflow and carry. The incoming carry is passed through when the shift length is zero.

A one-cycle start strobe captures the operation. On the next rising clock edge the registered result and flags appear, together with a one-cycle done pulse. Between operations the outputs hold their last values. The unit has no knowledge of instruction encoding or of the register file: the surrounding decode stage supplies the operand, both count sources, the mode and the current flags.

Top module: `asr_flag_unit`

## Requirements
- R1: The result is the operand shifted right by the effective count n. Each of the n vacated upper bits equals the operand's original bit 15, so n = 16 gives a result of all sign copies.
- R2: With mode_reg_i = 0 (immediate mode), n is the value of imm_i, except that imm_i = 0 gives n = 16.
- R3: With mode_reg_i = 1 (register mode), n is the value of cnt_reg_i, except that any value above 15 gives n = 16.
- R4: For n > 0, carry (flags_o bit 0) is the operand bit at position n-1 before the shift. For n = 16 this is the original bit 15.
- R5: For n = 0 (register mode, cnt_reg_i = 0), carry equals the incoming flags_i bit 0 and the result equals the operand.
- R6: Negative (flags_o bit 3) equals bit 15 of the result.
- R7: Zero (flags_o bit 2) is 1 exactly when the 16-bit result is 0.
- R8: Overflow (flags_o bit 1) is the XOR of operand bit 15 and result bit 15. Because the sign is kept, this is always 0.
- R9: A start_i sampled high at a rising edge produces the result and flags on that same edge, with done_o high for the following cycle only. Without start_i, result_o and flags_o hold their values and done_o is 0.
- R10: While rst_n is low at a rising edge, result_o, flags_o and done_o are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture strobe for one operation |
| mode_reg_i | input | 1 | Count source: 0 = immediate, 1 = register |
| opnd_i | input | 16 | Operand to be shifted |
| imm_i | input | 4 | Immediate shift count (0 means 16) |
| cnt_reg_i | input | 16 | Register shift count (above 15 means 16) |
| flags_i | input | 4 | Current flags {N,Z,V,C}; carry passes through for n = 0 |
| result_o | output | 16 | Registered shifted value |
| flags_o | output | 4 | Registered flags {N,Z,V,C} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every immediate code from 0 to 15 is applied to a set of operands: zero, one, both sign extremes, alternating bit patterns and a spread of mixed values. These show whether sign fill and per-position carry are correct, and whether code 0 becomes a full 16-place shift. Register counts of 0 to 20 and large values such as 0x8000 and 0xFFFF separate correct saturation from plain truncation of the low bits. Register count 0 is applied with both incoming carry values to tell pass-through apart from a recomputed carry. Idle cycles and back-to-back strobes check that the outputs hold between operations and that done pulses once per strobe.

// File: rtl/asr_pkg.sv
// asr_pkg: shared sizes and flag layout for the arithmetic shift-right unit.
// Assumes a data width that is a power of two.
package asr_pkg;
    localparam int DATA_W = 16;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;
endpackage

// File: rtl/asr_count_sel.sv
// asr_count_sel: turns the immediate or register count into an effective
// shift length of 0..WIDTH. An immediate of 0 maps to WIDTH, and register
// values above WIDTH-1 saturate to WIDTH. Purely combinational.
module asr_count_sel #(
    parameter int WIDTH = 16,
    localparam int IMM_W = $clog2(WIDTH),
    localparam int CNT_W = $clog2(WIDTH) + 1
) (
    input  logic             mode_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [WIDTH-1:0] cnt_reg_i,
    output logic [CNT_W-1:0] shamt_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

    // Select the count source and apply its saturation rule.
    always_comb begin
        if (mode_reg_i) begin
            shamt_o = (cnt_reg_i >= WIDTH'(WIDTH)) ? FULL : cnt_reg_i[CNT_W-1:0];
        end else begin
            shamt_o = (imm_i == '0) ? FULL : {1'b0, imm_i};
        end
    end
endmodule

// File: rtl/asr_barrel.sv
// asr_barrel: logarithmic arithmetic right shifter with sign fill, plus the
// carry taken from the last bit shifted out. Assumes shamt_i <= WIDTH.
// A zero shift length passes the incoming carry through.
module asr_barrel #(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH),
    localparam int CNT_W = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [CNT_W-1:0] shamt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    logic             sign;
    logic [WIDTH-1:0] stage [CNT_W+1];
    logic [CNT_W-1:0] last_idx;

    assign sign     = opnd_i[WIDTH-1];
    assign stage[0] = opnd_i;

    // One stage per count bit; stage k moves by 2**k places.
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        if ((2 ** k) >= WIDTH) begin : g_full
            assign stage[k+1] = shamt_i[k] ? {WIDTH{sign}} : stage[k];
        end else begin : g_part
            assign stage[k+1] = shamt_i[k]
                ? {{(2 ** k){sign}}, stage[k][WIDTH-1:(2 ** k)]}
                : stage[k];
        end
    end

    assign result_o = stage[CNT_W];

    // Pick the last bit shifted out, or keep the old carry for no shift.
    always_comb begin
        last_idx = shamt_i - 1'b1;
        if (shamt_i == '0) carry_o = carry_i;
        else               carry_o = opnd_i[last_idx[IDX_W-1:0]];
    end
endmodule

// File: rtl/asr_flag_gen.sv
// asr_flag_gen: derives N, Z and V from the shifted value and the original
// sign bit; the carry comes in already resolved. Purely combinational.
module asr_flag_gen #(
    parameter int WIDTH = 16
) (
    input  logic             orig_sign_i,
    input  logic [WIDTH-1:0] result_i,
    input  logic             carry_i,
    output asr_pkg::ccr_t    ccr_o
);
    // Assemble the flag record.
    always_comb begin
        ccr_o.neg   = result_i[WIDTH-1];
        ccr_o.zero  = (result_i == '0);
        ccr_o.ovf   = orig_sign_i ^ result_i[WIDTH-1];
        ccr_o.carry = carry_i;
    end
endmodule

// File: rtl/asr_flag_unit.sv
// asr_flag_unit: arithmetic shift-right execution unit. A start strobe
// captures the operation. Result and flags are registered on that edge, and
// done pulses for one cycle. Outputs hold between operations. Synchronous
// active-low reset clears every output.
module asr_flag_unit #(
    parameter int WIDTH = asr_pkg::DATA_W,
    localparam int IMM_W = $clog2(WIDTH),
    localparam int CNT_W = $clog2(WIDTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_reg_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [WIDTH-1:0] cnt_reg_i,
    input  logic [3:0]       flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_o,
    output logic             done_o
);
    logic [CNT_W-1:0] shamt;
    logic [WIDTH-1:0] shifted;
    logic             carry_nxt;
    asr_pkg::ccr_t    ccr_nxt;

    asr_count_sel #(.WIDTH(WIDTH)) u_cnt (
        .mode_reg_i (mode_reg_i),
        .imm_i      (imm_i),
        .cnt_reg_i  (cnt_reg_i),
        .shamt_o    (shamt)
    );

    asr_barrel #(.WIDTH(WIDTH)) u_shift (
        .opnd_i   (opnd_i),
        .shamt_i  (shamt),
        .carry_i  (flags_i[asr_pkg::FLAG_C]),
        .result_o (shifted),
        .carry_o  (carry_nxt)
    );

    asr_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .orig_sign_i (opnd_i[WIDTH-1]),
        .result_i    (shifted),
        .carry_i     (carry_nxt),
        .ccr_o       (ccr_nxt)
    );

    // Output registers: load on start, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                result_o <= shifted;
                flags_o  <= ccr_nxt;
            end
        end
    end
endmodule

// File: rtl/asr_flag_unit_chk.sv
// asr_flag_unit_chk: property checker bound to asr_flag_unit.
module asr_flag_unit_chk #(
    parameter int WIDTH = 16,
    localparam int IMM_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mode_reg_i,
    input logic [WIDTH-1:0] opnd_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [WIDTH-1:0] cnt_reg_i,
    input logic [3:0]       flags_i,
    input logic [WIDTH-1:0] result_o,
    input logic [3:0]       flags_o,
    input logic             done_o
);
    assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> result_o[WIDTH-1] == $past(opnd_i[WIDTH-1]));

    assert_imm_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_reg_i && imm_i == '0) |=>
        (result_o == {WIDTH{$past(opnd_i[WIDTH-1])}} && flags_o[0] == $past(opnd_i[WIDTH-1])));

    assert_reg_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_reg_i && cnt_reg_i >= WIDTH'(WIDTH)) |=>
        result_o == {WIDTH{$past(opnd_i[WIDTH-1])}});

    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_reg_i && cnt_reg_i == '0) |=>
        (result_o == $past(opnd_i) && flags_o[0] == $past(flags_i[0])));

    assert_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[3] == result_o[WIDTH-1]);

    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[2] == (result_o == '0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !flags_o[1]);

    assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && $stable(result_o) && $stable(flags_o)));

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && flags_o == '0 && !done_o));
endmodule

bind asr_flag_unit asr_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_reg_i (mode_reg_i),
    .opnd_i     (opnd_i),
    .imm_i      (imm_i),
    .cnt_reg_i  (cnt_reg_i),
    .flags_i    (flags_i),
    .result_o   (result_o),
    .flags_o    (flags_o),
    .done_o     (done_o)
);

// File: tb/asr_flag_unit_tb.sv
// asr_flag_unit_tb: directed bench, one task per scenario.
module asr_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_reg_i = 1'b0;
    logic [15:0] opnd_i = '0;
    logic [3:0]  imm_i = '0;
    logic [15:0] cnt_reg_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] result_o;
    logic [3:0]  flags_o;
    logic        done_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    asr_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_reg_i(mode_reg_i),
        .opnd_i(opnd_i), .imm_i(imm_i), .cnt_reg_i(cnt_reg_i), .flags_i(flags_i),
        .result_o(result_o), .flags_o(flags_o), .done_o(done_o)
    );

    logic [15:0] opnds [12] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h7FFF,
                               16'hAAAA, 16'h5555, 16'h1234, 16'h8001, 16'hC3A5,
                               16'h0F0F, 16'hFE01};

    // Compare one value and report a failure line.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: effective count from the requirements (R2, R3).
    function automatic int eff_n(input logic m, input logic [3:0] im, input logic [15:0] rc);
        if (m) return (rc > 16'd15) ? 16 : int'(rc);
        return (im == 4'd0) ? 16 : int'(im);
    endfunction

    // Issue one operation and check result and flags against the model.
    task automatic run_op(input string req, input logic m, input logic [15:0] op,
                          input logic [3:0] im, input logic [15:0] rc, input logic [3:0] fin);
        int n;
        logic [15:0] exp_r;
        logic [3:0]  exp_f;
        n = eff_n(m, im, rc);
        exp_r = 16'($signed(op) >>> n);
        exp_f[3] = exp_r[15];
        exp_f[2] = (exp_r == 16'h0);
        exp_f[1] = op[15] ^ exp_r[15];
        exp_f[0] = (n == 0) ? fin[0] : op[n-1];
        @(negedge clk);
        start_i = 1'b1; mode_reg_i = m; opnd_i = op; imm_i = im; cnt_reg_i = rc; flags_i = fin;
        @(negedge clk);
        start_i = 1'b0;
        chk({req, " result"}, 32'(result_o), 32'(exp_r));
        chk({req, " flags"}, 32'(flags_o), 32'(exp_f));
        chk("R9 done", 32'(done_o), 32'd1);
    endtask

    // R10: outputs cleared under reset, even after a prior operation.
    task automatic test_reset();
        chk("R10 result", 32'(result_o), 32'd0);
        chk("R10 flags", 32'(flags_o), 32'd0);
        chk("R10 done", 32'(done_o), 32'd0);
    endtask

    // R1, R2, R4, R6, R7, R8: all immediate codes over the operand set.
    task automatic test_imm_sweep();
        foreach (opnds[i])
            for (int c = 0; c < 16; c++)
                run_op("R2 imm", 1'b0, opnds[i], 4'(c), 16'h0, 4'h0);
    endtask

    // R1, R3, R4: register counts across and above the saturation point.
    task automatic test_reg_sweep();
        foreach (opnds[i]) begin
            for (int c = 1; c < 21; c++)
                run_op("R3 reg", 1'b1, opnds[i], 4'h5, 16'(c), 4'h0);
            run_op("R3 reg big", 1'b1, opnds[i], 4'h1, 16'h8000, 4'h0);
            run_op("R3 reg max", 1'b1, opnds[i], 4'h1, 16'hFFFF, 4'h0);
            run_op("R3 reg 0x110", 1'b1, opnds[i], 4'h1, 16'h0110, 4'h0);
        end
    endtask

    // R5: zero-length shift keeps the incoming carry, both polarities.
    task automatic test_zero_len();
        foreach (opnds[i]) begin
            run_op("R5 keep c1", 1'b1, opnds[i], 4'h3, 16'h0, 4'h1);
            run_op("R5 keep c0", 1'b1, opnds[i], 4'h3, 16'h0, 4'hE);
        end
    endtask

    // R9: without start, outputs hold and done stays low even as inputs move.
    task automatic test_hold();
        logic [15:0] r0;
        logic [3:0]  f0;
        run_op("R9 setup", 1'b0, 16'h8421, 4'h2, 16'h0, 4'h0);
        r0 = result_o; f0 = flags_o;
        @(negedge clk);
        chk("R9 done low", 32'(done_o), 32'd0);
        opnd_i = 16'h0000; imm_i = 4'h7; mode_reg_i = 1'b1; cnt_reg_i = 16'h3; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        chk("R9 hold result", 32'(result_o), 32'(r0));
        chk("R9 hold flags", 32'(flags_o), 32'(f0));
        chk("R9 done idle", 32'(done_o), 32'd0);
    endtask

    // R9: back-to-back strobes each deliver their own result.
    task automatic test_back_to_back();
        @(negedge clk);
        start_i = 1'b1; mode_reg_i = 1'b0; opnd_i = 16'hF000; imm_i = 4'h4;
        @(negedge clk);
        chk("R9 b2b first", 32'(result_o), 32'h0000FF00);
        opnd_i = 16'h0100; imm_i = 4'h8;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 b2b second", 32'(result_o), 32'h00000001);
        chk("R9 b2b done", 32'(done_o), 32'd1);
        @(negedge clk);
        chk("R9 b2b done end", 32'(done_o), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_imm_sweep();
        test_reg_sweep();
        test_zero_len();
        test_hold();
        test_back_to_back();
        run_op("R1 pre-reset", 1'b0, 16'h9000, 4'h3, 16'h0, 4'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule